// File: doc/BRIEF.md
# Low-Leakage Stop Sequencer

This block takes a chip down into one of four very-low-leakage stop levels and brings it back. Software selects a level and arms the sequencer through a two-word register file that only privileged (supervisor) bus accesses may change. When the core then raises its wait-for-interrupt request, the sequencer works through a fixed order. It gates the core clock first. It waits until every supporting peripheral acknowledges the stop. It then gates the system and bus clocks. Last, it drives the power-domain controls for the chosen level.

Each level keeps a different set of domains alive: three RAM partitions, the 1 kHz low-power oscillator and the power-on-reset detector. Two option bits refine levels 2 and 0. Internal logic is lost on every level, so a wake request reverses the order (power, then bus clocks, then core clock) and ends with a one-cycle wake-reset pulse instead of a plain resume. The level and option bits are captured when entry starts, so register writes made during sleep do not change the level in progress.

Top module: `lls_seq`

## Requirements
- R1: After reset, core_clk_en, sys_clk_en, logic_pwr_en, lpo_en and por_en are 1, ram_pwr_en is 3'b111, io_hold, wake_rst and bus_err are 0, and both registers read 0.
- R2: A supervisor write stores its data. Register at bus_addr 0 holds the level in bits [1:0] and the arm bit in bit 2. Register at bus_addr 1 holds the RAM partition 2 keep option in bit 0 and the POR keep option in bit 1. Unused bits read 0. A read of either register, with any privilege, returns the value on bus_rdata in the cycle after the access.
- R3: A user-mode write (bus_super=0) leaves the registers unchanged, and bus_err is 1 for exactly the cycle after the access.
- R4: A wfi_req while the arm bit is 0 is ignored, and all clock and power outputs keep their run values.
- R5: An accepted wfi_req clears core_clk_en in the next cycle, and sys_clk_en is never 0 while core_clk_en is 1.
- R6: sys_clk_en falls only after all periph_ack inputs have been seen high together; it falls two cycles after the cycle in which they are first all high. While any acknowledge is low it stays 1.
- R7: Power outputs change one cycle after sys_clk_en falls. logic_pwr_en goes to 0 and io_hold to 1 on every level. Level 3 keeps all three RAM partitions, the oscillator and POR enabled.
- R8: Level 2 keeps RAM partition 1 (ram_pwr_en bit 0) powered and turns partition 3 (bit 2) off. Partition 2 (bit 1) stays powered only when the RAM2 keep option is 1.
- R9: Level 1 turns off all RAM partitions (ram_pwr_en 3'b000) and keeps lpo_en and por_en at 1.
- R10: Level 0 turns off all RAM partitions and lpo_en. por_en is 1 only when the POR keep option is 1.
- R11: A wake_req in the powered-down state restores all power enables and clears io_hold in the next cycle. sys_clk_en returns one cycle later, core_clk_en one cycle after that, and wake_rst is then 1 for exactly one cycle.
- R12: A wake_req before the powered-down state is reached has no effect on the entry sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_super | input | 1 | 1 = supervisor access, 0 = user access |
| bus_addr | input | 1 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| bus_err | output | 1 | Bus error response for a rejected write |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| periph_ack | input | N_ACK | Stop acknowledges from the peripherals |
| wake_req | input | 1 | Wake request |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System and bus clock enable |
| logic_pwr_en | output | 1 | Internal logic power enable |
| ram_pwr_en | output | 3 | RAM partition power enables, bit 0 = partition 1 |
| lpo_en | output | 1 | Low-power oscillator enable |
| por_en | output | 1 | Power-on-reset circuit enable |
| io_hold | output | 1 | I/O state hold |
| wake_rst | output | 1 | One-cycle reset-type wake pulse |

## Verification
The bench builds the block with N_ACK=3 and the default 8-bit data width. This puts every combination of partial acknowledges within reach, so one missing acknowledge among several can be shown to block the bus clock gate. It also drives both option bits to both values on levels 2 and 0, and sends wake requests both early and at the proper time.

// File: rtl/lls_pkg.sv
package lls_pkg;
  localparam int NRAM = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GATE_CORE, ST_WAIT_ACK, ST_GATE_BUS,
    ST_DOWN, ST_REL_BUS, ST_REL_CORE, ST_WAKE_RST
  } seq_state_t;

  typedef struct packed {
    logic            logic_en;
    logic [NRAM-1:0] ram_en;
    logic            lpo_en;
    logic            por_en;
    logic            io_hold;
  } pwr_t;

  localparam pwr_t PWR_RUN = '{logic_en: 1'b1, ram_en: {NRAM{1'b1}},
                               lpo_en: 1'b1, por_en: 1'b1, io_hold: 1'b0};
endpackage

// File: rtl/lls_regs.sv
module lls_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic          bus_super,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic [1:0]    lvl_o,
  output logic          arm_o,
  output logic          ram2_keep_o,
  output logic          por_keep_o
);
  logic          wr_ok;
  logic          wr_bad;
  logic [DW-1:0] rd_val;

  assign wr_ok  = bus_valid && bus_write && bus_super;
  assign wr_bad = bus_valid && bus_write && !bus_super;

  always_comb begin
    rd_val = '0;
    if (bus_addr == 1'b0) begin
      rd_val[1:0] = lvl_o;
      rd_val[2]   = arm_o;
    end else begin
      rd_val[0] = ram2_keep_o;
      rd_val[1] = por_keep_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o       <= 2'd0;
      arm_o       <= 1'b0;
      ram2_keep_o <= 1'b0;
      por_keep_o  <= 1'b0;
      bus_rdata   <= '0;
      bus_err     <= 1'b0;
    end else begin
      bus_err <= wr_bad;
      if (wr_ok) begin
        if (bus_addr == 1'b0) begin
          lvl_o <= bus_wdata[1:0];
          arm_o <= bus_wdata[2];
        end else begin
          ram2_keep_o <= bus_wdata[0];
          por_keep_o  <= bus_wdata[1];
        end
      end
      if (bus_valid && !bus_write) bus_rdata <= rd_val;
    end
  end

  p_user_err_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && !bus_super) |=> bus_err);

  p_user_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && !bus_super) |=> ($stable(lvl_o) && $stable(arm_o)
      && $stable(ram2_keep_o) && $stable(por_keep_o)));
endmodule

// File: rtl/lls_pwrmap.sv
module lls_pwrmap
  import lls_pkg::*;
(
  input  logic [1:0] lvl,
  input  logic       ram2_keep,
  input  logic       por_keep,
  output pwr_t       map_o
);
  for (genvar i = 0; i < NRAM; i++) begin : g_ram
    logic keep;
    always_comb begin
      case (lvl)
        2'd3:    keep = 1'b1;
        2'd2:    keep = (i == 0) ? 1'b1 : ((i == 1) ? ram2_keep : 1'b0);
        default: keep = 1'b0;
      endcase
    end
    assign map_o.ram_en[i] = keep;
  end

  assign map_o.logic_en = 1'b0;
  assign map_o.io_hold  = 1'b1;
  assign map_o.lpo_en   = (lvl != 2'd0);
  assign map_o.por_en   = (lvl != 2'd0) || por_keep;
endmodule

// File: rtl/lls_fsm.sv
module lls_fsm
  import lls_pkg::*;
#(
  parameter int N_ACK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_req,
  input  logic             arm,
  input  logic [1:0]       lvl,
  input  logic             ram2_keep,
  input  logic             por_keep,
  input  logic [N_ACK-1:0] periph_ack,
  input  logic             wake_req,
  input  pwr_t             map_i,
  output logic [1:0]       snap_lvl,
  output logic             snap_ram2,
  output logic             snap_por,
  output logic             core_clk_en,
  output logic             sys_clk_en,
  output pwr_t             pwr_o,
  output logic             wake_rst
);
  seq_state_t       state;
  logic [N_ACK-1:0] ack_q;
  logic             ack_all;

  for (genvar i = 0; i < N_ACK; i++) begin : g_ack
    always_ff @(posedge clk) begin
      if (rst) ack_q[i] <= 1'b0;
      else     ack_q[i] <= periph_ack[i];
    end
  end
  assign ack_all = &ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      core_clk_en <= 1'b1;
      sys_clk_en  <= 1'b1;
      pwr_o       <= PWR_RUN;
      wake_rst    <= 1'b0;
      snap_lvl    <= 2'd0;
      snap_ram2   <= 1'b0;
      snap_por    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          wake_rst <= 1'b0;
          if (wfi_req && arm) begin
            core_clk_en <= 1'b0;
            snap_lvl    <= lvl;
            snap_ram2   <= ram2_keep;
            snap_por    <= por_keep;
            state       <= ST_GATE_CORE;
          end
        end
        ST_GATE_CORE: state <= ST_WAIT_ACK;
        ST_WAIT_ACK: begin
          if (ack_all) begin
            sys_clk_en <= 1'b0;
            state      <= ST_GATE_BUS;
          end
        end
        ST_GATE_BUS: begin
          pwr_o <= map_i;
          state <= ST_DOWN;
        end
        ST_DOWN: begin
          if (wake_req) begin
            pwr_o <= PWR_RUN;
            state <= ST_REL_BUS;
          end
        end
        ST_REL_BUS: begin
          sys_clk_en <= 1'b1;
          state      <= ST_REL_CORE;
        end
        ST_REL_CORE: begin
          core_clk_en <= 1'b1;
          state       <= ST_WAKE_RST;
        end
        default: begin
          wake_rst <= 1'b1;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  p_core_first_r5: assert property (@(posedge clk) disable iff (rst)
    !sys_clk_en |-> !core_clk_en);

  p_ack_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk_en) |-> $past(&periph_ack, 2));

  p_pwr_after_clk_r7: assert property (@(posedge clk) disable iff (rst)
    !pwr_o.logic_en |-> (!sys_clk_en && !core_clk_en));

  p_wake_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    wake_rst |=> !wake_rst);

  p_wake_after_core_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_rst) |-> (core_clk_en && sys_clk_en && pwr_o.logic_en));
endmodule

// File: rtl/lls_seq.sv
module lls_seq
  import lls_pkg::*;
#(
  parameter int DW    = 8,
  parameter int N_ACK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic             bus_super,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  input  logic             wfi_req,
  input  logic [N_ACK-1:0] periph_ack,
  input  logic             wake_req,
  output logic             core_clk_en,
  output logic             sys_clk_en,
  output logic             logic_pwr_en,
  output logic [NRAM-1:0]  ram_pwr_en,
  output logic             lpo_en,
  output logic             por_en,
  output logic             io_hold,
  output logic             wake_rst
);
  logic [1:0] lvl, snap_lvl;
  logic       arm, ram2_keep, por_keep, snap_ram2, snap_por;
  pwr_t       map, pwr;

  lls_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_super(bus_super), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .lvl_o(lvl), .arm_o(arm),
    .ram2_keep_o(ram2_keep), .por_keep_o(por_keep)
  );

  lls_pwrmap u_map (
    .lvl(snap_lvl), .ram2_keep(snap_ram2), .por_keep(snap_por), .map_o(map)
  );

  lls_fsm #(.N_ACK(N_ACK)) u_fsm (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .arm(arm), .lvl(lvl),
    .ram2_keep(ram2_keep), .por_keep(por_keep), .periph_ack(periph_ack),
    .wake_req(wake_req), .map_i(map), .snap_lvl(snap_lvl),
    .snap_ram2(snap_ram2), .snap_por(snap_por), .core_clk_en(core_clk_en),
    .sys_clk_en(sys_clk_en), .pwr_o(pwr), .wake_rst(wake_rst)
  );

  assign logic_pwr_en = pwr.logic_en;
  assign ram_pwr_en   = pwr.ram_en;
  assign lpo_en       = pwr.lpo_en;
  assign por_en       = pwr.por_en;
  assign io_hold      = pwr.io_hold;
endmodule

// File: tb/sim_lls_seq.sv
module sim_lls_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NA = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0, bus_super = 0, bus_addr = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_err, wfi_req = 0, wake_req = 0;
  logic [NA-1:0] periph_ack = '0;
  logic core_clk_en, sys_clk_en, logic_pwr_en, lpo_en, por_en, io_hold, wake_rst;
  logic [2:0] ram_pwr_en;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lls_seq #(.DW(DW), .N_ACK(NA)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_super(bus_super), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .wfi_req(wfi_req),
    .periph_ack(periph_ack), .wake_req(wake_req), .core_clk_en(core_clk_en),
    .sys_clk_en(sys_clk_en), .logic_pwr_en(logic_pwr_en), .ram_pwr_en(ram_pwr_en),
    .lpo_en(lpo_en), .por_en(por_en), .io_hold(io_hold), .wake_rst(wake_rst)
  );

  // behavioural reference model
  int phase;
  bit m_ackq, m_core, m_sys, m_logic, m_lpo, m_por, m_hold, m_wrst, m_err;
  bit [2:0] m_ram;
  bit [1:0] m_lvl, s_lvl;
  bit m_arm, m_k2, m_kp, s_k2, s_kp;
  bit [DW-1:0] m_rdata;

  task automatic m_run();
    m_logic = 1; m_ram = 3'b111; m_lpo = 1; m_por = 1; m_hold = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; m_ackq = 0; m_core = 1; m_sys = 1; m_wrst = 0; m_err = 0;
      m_run(); m_lvl = 0; m_arm = 0; m_k2 = 0; m_kp = 0; m_rdata = '0;
    end else begin
      case (phase)
        0: begin
          m_wrst = 0;
          if (wfi_req && m_arm) begin
            m_core = 0; s_lvl = m_lvl; s_k2 = m_k2; s_kp = m_kp; phase = 1;
          end
        end
        1: phase = 2;
        2: if (m_ackq) begin m_sys = 0; phase = 3; end
        3: begin
          m_logic = 0; m_hold = 1;
          m_lpo = (s_lvl != 0); m_por = (s_lvl != 0) || s_kp;
          case (s_lvl)
            3: m_ram = 3'b111;
            2: m_ram = {1'b0, s_k2, 1'b1};
            default: m_ram = 3'b000;
          endcase
          phase = 4;
        end
        4: if (wake_req) begin m_run(); phase = 5; end
        5: begin m_sys = 1; phase = 6; end
        6: begin m_core = 1; phase = 7; end
        default: begin m_wrst = 1; phase = 0; end
      endcase
      m_ackq = &periph_ack;
      m_err = bus_valid && bus_write && !bus_super;
      if (bus_valid && bus_write && bus_super) begin
        if (!bus_addr) begin m_lvl = bus_wdata[1:0]; m_arm = bus_wdata[2]; end
        else begin m_k2 = bus_wdata[0]; m_kp = bus_wdata[1]; end
      end
      if (bus_valid && !bus_write)
        m_rdata = bus_addr ? {{(DW-2){1'b0}}, m_kp, m_k2}
                           : {{(DW-3){1'b0}}, m_arm, m_lvl};
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R5 core_clk_en", core_clk_en, m_core);
    chk("R6 sys_clk_en", sys_clk_en, m_sys);
    chk("R7 logic_pwr_en", logic_pwr_en, m_logic);
    chk("R7 ram_pwr_en", ram_pwr_en, m_ram);
    chk("R7 lpo_en", lpo_en, m_lpo);
    chk("R7 por_en", por_en, m_por);
    chk("R7 io_hold", io_hold, m_hold);
    chk("R11 wake_rst", wake_rst, m_wrst);
    chk("R3 bus_err", bus_err, m_err);
    chk("R2 bus_rdata", bus_rdata, m_rdata);
  end

  task automatic bus_wr(bit a, int d, bit sup);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_super = sup; bus_addr = a; bus_wdata = d[DW-1:0];
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(bit a, bit sup);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_super = sup; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi_req = 1;
    @(negedge clk); wfi_req = 0;
  endtask

  task automatic sleep_wake(int lvl, bit k2, bit kp, int ram_x, bit lpo_x, bit por_x, string tag);
    bus_wr(1, {kp, k2}, 1);
    bus_wr(0, 4 | lvl, 1);
    periph_ack = 3'b000;
    pulse_wfi();
    chk("R5 core gated after wfi", core_clk_en, 0);
    periph_ack = 3'b101;
    @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    repeat (3) @(negedge clk);
    chk("R6 partial ack keeps sys clock", sys_clk_en, 1);
    chk("R12 early wake ignored", core_clk_en, 0);
    periph_ack = 3'b111;
    @(negedge clk);
    chk("R6 sys clock before ack seen", sys_clk_en, 1);
    @(negedge clk);
    chk("R6 sys clock gated", sys_clk_en, 0);
    chk("R6 power not yet changed", logic_pwr_en, 1);
    @(negedge clk);
    chk({tag, " ram map"}, ram_pwr_en, ram_x);
    chk({tag, " lpo"}, lpo_en, lpo_x);
    chk({tag, " por"}, por_en, por_x);
    chk("R7 io hold", io_hold, 1);
    chk("R7 logic off", logic_pwr_en, 0);
    periph_ack = 3'b000;
    bus_wr(0, 0, 1);
    repeat (2) @(negedge clk);
    chk("R12 still down", io_hold, 1);
    @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    chk("R11 power back", logic_pwr_en, 1);
    chk("R11 hold released", io_hold, 0);
    chk("R11 sys still off", sys_clk_en, 0);
    @(negedge clk);
    chk("R11 sys back", sys_clk_en, 1);
    chk("R11 core still off", core_clk_en, 0);
    @(negedge clk);
    chk("R11 core back", core_clk_en, 1);
    chk("R11 no pulse yet", wake_rst, 0);
    @(negedge clk);
    chk("R11 wake pulse", wake_rst, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", wake_rst, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 core clk", core_clk_en, 1);
    chk("R1 sys clk", sys_clk_en, 1);
    chk("R1 ram", ram_pwr_en, 3'b111);
    chk("R1 hold", io_hold, 0);
    bus_rd(0, 0);
    chk("R1 reg0 zero", bus_rdata, 0);

    bus_wr(0, 8'hFE, 1);
    bus_rd(0, 0);
    chk("R2 reg0 readback user read", bus_rdata, 8'h06);
    bus_wr(1, 8'hFF, 1);
    bus_rd(1, 1);
    chk("R2 reg1 readback", bus_rdata, 8'h03);

    bus_wr(0, 8'h01, 0);
    chk("R3 bus_err", bus_err, 1);
    @(negedge clk);
    chk("R3 bus_err one cycle", bus_err, 0);
    bus_rd(0, 1);
    chk("R3 reg0 unchanged", bus_rdata, 8'h06);

    bus_wr(0, 8'h03, 1);
    pulse_wfi();
    repeat (4) @(negedge clk);
    chk("R4 core clock kept", core_clk_en, 1);
    chk("R4 power kept", logic_pwr_en, 1);

    sleep_wake(3, 0, 0, 3'b111, 1, 1, "R7 level3");
    sleep_wake(2, 0, 0, 3'b001, 1, 1, "R8 level2 keep0");
    sleep_wake(2, 1, 0, 3'b011, 1, 1, "R8 level2 keep1");
    sleep_wake(1, 1, 1, 3'b000, 1, 1, "R9 level1");
    sleep_wake(0, 1, 0, 3'b000, 0, 0, "R10 level0 por0");
    sleep_wake(0, 0, 1, 3'b000, 0, 1, "R10 level0 por1");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule